// File: doc/BRIEF.md
# Per-Channel Decimation Phase Offset Controller

This block sets when each of three ADC channels closes its decimation window. All channels share one modulator-rate tick. A single reference counter runs over one conversion period of OSR ticks. Each channel has a signed offset, counted in whole modulator ticks. The block clips that offset to the range that is legal for the selected OSR and uses the result to slide the channel's window-boundary strobe away from the reference. A positive offset delays the window and a negative one advances it.

The outputs are one boundary strobe per channel, the offsets currently in force (for readback) and a single data-ready pulse. The data-ready pulse follows the channel whose window closes last. Offsets and the OSR selection are sampled only when the reference period wraps. A window is therefore never cut short mid-period, and the data-ready pulse marks the moment new settings can take hold.

Top module: `decim_phase_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the counter is cleared, `win_strobe` and `data_rdy` are 0 after that edge, and `phase_active` holds the clipped values of the current `phase_raw` under the current `osr_code`.
- R2: The counter advances only on edges where `mod_tick` is 1. It runs from 0 to OSR-1 and then wraps, so with unchanged settings each channel strobes exactly once in every OSR ticks.
- R3: `osr_code` selects OSR = 64 << code for codes 0..8. For OSR up to 1024, a raw offset below -OSR/2 becomes -OSR/2, and one above OSR/2-1 becomes OSR/2-1. For example, at OSR 128 a raw value of 100 becomes 63 and -100 becomes -64.
- R4: For OSR 2048 and above, every 10-bit value -512..511 passes unchanged. Codes 9..15 behave as code 8 (OSR 16384).
- R5: Channel n's strobe is high for one cycle, in the cycle after an edge where `mod_tick` is 1 and the counter equals (OSR-1+phase_n) mod OSR. Channel n's offset occupies `phase_raw[10n+9:10n]` and `phase_active[10n+9:10n]` as two's complement.
- R6: New raw offsets and OSR codes reach `phase_active` and the strobe timing only on the edge where the counter wraps (tick with counter at OSR-1). On every other edge they have no effect.
- R7: `data_rdy` is high for one cycle, one cycle after the strobe of the channel with the largest active offset. When offsets are equal, the lowest channel index wins.
- R8: After reset, no strobe occurs before the counter has completed its first full period.
- R9: No strobe is produced in a cycle that does not follow a `mod_tick` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_tick | input | 1 | Modulator-rate enable |
| osr_code | input | 4 | OSR select, 64 << code, capped at 16384 |
| phase_raw | input | 30 | Raw signed offsets, 10 bits per channel |
| win_strobe | output | 3 | Per-channel window-boundary strobe |
| phase_active | output | 30 | Clipped offsets in force, 10 bits per channel |
| data_rdy | output | 1 | Single data-ready pulse |

## Verification
The assertions assume that `rst` is held high for at least one edge before it is first released, and that `osr_code` and `phase_raw` are driven, never unknown, whenever reset is low. Between wraps, the inputs may change freely. The stimulus drives every input on the falling clock edge, so they are stable at each rising edge. Reset is asserted from time zero, and offsets and OSR codes are switched both in mid-period and across the wrap. The tick is driven both continuously and with random gaps, which exercises the rule that settings are sampled only at the wrap.

// File: rtl/phz_pkg.sv
package phz_pkg;
    parameter int PH_W         = 10;
    parameter int OSR_LOG2_MIN = 6;
    parameter int OSR_CODE_MAX = 8;
    parameter int CAP_LOG2     = 10;
    localparam int CNT_W       = OSR_LOG2_MIN + OSR_CODE_MAX;
    localparam int LG_W        = $clog2(CNT_W + 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [LG_W-1:0]  lg_t;

    function automatic lg_t code_to_lg(input logic [3:0] code);
        if (int'(code) > OSR_CODE_MAX)
            return lg_t'(OSR_LOG2_MIN + OSR_CODE_MAX);
        return lg_t'(OSR_LOG2_MIN + int'(code));
    endfunction
endpackage

// File: rtl/phz_clip.sv
module phz_clip
    import phz_pkg::*;
(
    input  lg_t              lg,
    input  logic [PH_W-1:0]  raw,
    output logic [PH_W-1:0]  clipped
);
    logic signed [PH_W:0] half_s;
    logic signed [PH_W:0] raw_s;

    always_comb begin
        raw_s   = {raw[PH_W-1], raw};
        half_s  = '0;
        clipped = raw;
        if (int'(lg) <= CAP_LOG2) begin
            half_s = (PH_W+1)'(1) <<< (lg - lg_t'(1));
            if (raw_s > half_s - (PH_W+1)'(1))
                clipped = PH_W'(half_s - (PH_W+1)'(1));
            else if (raw_s < -half_s)
                clipped = PH_W'(-half_s);
        end
    end
endmodule

// File: rtl/phz_max_pick.sv
module phz_max_pick
    import phz_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH*PH_W-1:0] ph,
    output logic [IDX_W-1:0]       idx
);
    always_comb begin
        logic signed [PH_W-1:0] best;
        idx  = '0;
        best = $signed(ph[PH_W-1:0]);
        for (int i = 1; i < NUM_CH; i++) begin
            if ($signed(ph[i*PH_W +: PH_W]) > best) begin
                best = $signed(ph[i*PH_W +: PH_W]);
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/decim_phase_ctrl.sv
module decim_phase_ctrl
    import phz_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int PV_W  = NUM_CH * PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_tick,
    input  logic [3:0]        osr_code,
    input  logic [PV_W-1:0]   phase_raw,
    output logic [NUM_CH-1:0] win_strobe,
    output logic [PV_W-1:0]   phase_active,
    output logic              data_rdy
);
    typedef struct packed {
        cnt_t              cnt;
        lg_t               lg;
        logic [PV_W-1:0]   ph;
        logic [IDX_W-1:0]  maxi;
        logic              armed;
        logic [NUM_CH-1:0] stb;
        logic              drdy;
    } st_t;

    st_t s_d, s_q;

    lg_t              lg_in;
    logic [PV_W-1:0]  clip_in;
    logic [IDX_W-1:0] maxi_in;
    cnt_t             osr_m1;
    logic [CNT_W:0]   osr_full;
    cnt_t             targ [NUM_CH];
    logic             wrap;
    logic             load;

    assign lg_in = code_to_lg(osr_code);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [CNT_W:0] sum;
        phz_clip u_clip (
            .lg      (lg_in),
            .raw     (phase_raw[n*PH_W +: PH_W]),
            .clipped (clip_in[n*PH_W +: PH_W])
        );
        assign sum = {1'b0, osr_m1}
                   + {{(CNT_W+1-PH_W){s_q.ph[n*PH_W+PH_W-1]}}, s_q.ph[n*PH_W +: PH_W]};
        assign targ[n] = sum[CNT_W-1:0] & osr_m1;
    end

    phz_max_pick #(.NUM_CH(NUM_CH)) u_max (
        .ph  (clip_in),
        .idx (maxi_in)
    );

    always_comb begin
        osr_full = (CNT_W+1)'(1) << s_q.lg;
        osr_m1   = cnt_t'(osr_full - (CNT_W+1)'(1));
        wrap     = mod_tick && (s_q.cnt == osr_m1);
        load     = rst || wrap;
    end

    always_comb begin
        s_d      = s_q;
        s_d.drdy = s_q.stb[s_q.maxi];
        for (int n = 0; n < NUM_CH; n++)
            s_d.stb[n] = mod_tick && s_q.armed && (s_q.cnt == targ[n]);
        if (mod_tick)
            s_d.cnt = wrap ? '0 : s_q.cnt + cnt_t'(1);
        if (wrap)
            s_d.armed = 1'b1;
        if (load) begin
            s_d.lg   = lg_in;
            s_d.ph   = clip_in;
            s_d.maxi = maxi_in;
        end
        if (rst) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b0;
            s_d.stb   = '0;
            s_d.drdy  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign win_strobe   = s_q.stb;
    assign phase_active = s_q.ph;
    assign data_rdy     = s_q.drdy;

    // R2: counter never leaves the active period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= osr_m1);

    // R9: strobes only follow a tick edge
    p_strobe_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (win_strobe != '0) |-> $past(mod_tick));

    // R7: data-ready always trails a strobe by one cycle
    p_drdy_src_r7: assert property (@(posedge clk) disable iff (rst)
        data_rdy |-> ($past(win_strobe) != '0));

    // R8: quiet until the first period has completed
    p_unarmed_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(s_q.armed) |-> (win_strobe == '0));

    // R6: settings only change on a load edge
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> ($stable(phase_active) && $stable(s_q.lg)));

    // R3: active offsets lie inside the legal window
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        logic signed [PH_W:0] half_a;
        logic signed [PH_W:0] ph_a;
        assign half_a = (PH_W+1)'(1) <<< (s_q.lg - lg_t'(1));
        assign ph_a   = {s_q.ph[n*PH_W+PH_W-1], s_q.ph[n*PH_W +: PH_W]};
        p_clip_range_r3: assert property (@(posedge clk) disable iff (rst)
            (int'(s_q.lg) > CAP_LOG2) || ((ph_a >= -half_a) && (ph_a < half_a)));
    end
endmodule

// File: tb/decim_phase_ctrl_tb_top.sv
module decim_phase_ctrl_tb_top;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_tick = 1'b0;
    logic [3:0]  osr_code = 4'd1;
    logic [29:0] phase_raw = '0;
    logic [2:0]  win_strobe;
    logic [29:0] phase_active;
    logic        data_rdy;

    int checks = 0;
    int errors = 0;
    int raw_i [NCH];
    int cycles = 0;
    bit done = 0;

    // behavioural model state
    int m_cnt, m_lg, m_max;
    int m_ph [NCH];
    bit m_armed, m_drdy, m_valid;
    bit m_stb [NCH];

    always #10 clk = ~clk;

    decim_phase_ctrl dut_i (
        .clk(clk), .rst(rst), .mod_tick(mod_tick), .osr_code(osr_code),
        .phase_raw(phase_raw), .win_strobe(win_strobe),
        .phase_active(phase_active), .data_rdy(data_rdy)
    );

    function automatic int lg_of(input int code);
        return (code > 8) ? 14 : code + 6;
    endfunction

    function automatic int clipm(input int v, input int lg);
        int half;
        if (lg > 10) return v;
        half = 1 << (lg - 1);
        if (v > half - 1) return half - 1;
        if (v < -half) return -half;
        return v;
    endfunction

    task automatic reload_model();
        m_lg  = lg_of(int'(osr_code));
        m_max = 0;
        for (int n = 0; n < NCH; n++) m_ph[n] = clipm(raw_i[n], m_lg);
        for (int n = 1; n < NCH; n++) if (m_ph[n] > m_ph[m_max]) m_max = n;
    endtask

    always @(posedge clk) begin
        int osr;
        bit nd;
        bit ns [NCH];
        cycles++;
        m_valid = 1;
        osr = 1 << m_lg;
        nd = m_stb[m_max];
        for (int n = 0; n < NCH; n++)
            ns[n] = mod_tick && m_armed && (m_cnt == ((osr - 1 + m_ph[n] + osr) % osr));
        if (rst) begin
            m_cnt = 0; m_armed = 0; nd = 0;
            for (int n = 0; n < NCH; n++) ns[n] = 0;
            reload_model();
        end else if (mod_tick) begin
            if (m_cnt == osr - 1) begin
                m_cnt = 0; m_armed = 1;
                reload_model();
            end else m_cnt++;
        end
        m_drdy = nd;
        for (int n = 0; n < NCH; n++) m_stb[n] = ns[n];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid && !done) begin
            for (int n = 0; n < NCH; n++) begin
                check(win_strobe[n] == m_stb[n], "R5 strobe", int'(win_strobe[n]), int'(m_stb[n]));
                check($signed(phase_active[n*10 +: 10]) == m_ph[n], "R6 readback",
                      int'($signed(phase_active[n*10 +: 10])), m_ph[n]);
            end
            check(data_rdy == m_drdy, "R7 data_rdy", int'(data_rdy), int'(m_drdy));
        end
    end

    task automatic set_ph(input int a, input int b, input int c);
        raw_i[0] = a; raw_i[1] = b; raw_i[2] = c;
        phase_raw = {10'(c), 10'(b), 10'(a)};
    endtask

    task automatic run(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mod_tick = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
        end
    endtask

    function automatic int act(input int n);
        return int'($signed(phase_active[n*10 +: 10]));
    endfunction

    task automatic finish_up();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_up();
        end
    end

    initial begin
        int cnt;
        set_ph(100, -100, 5);
        osr_code = 4'd1;
        repeat (3) @(negedge clk);
        // R1 and R3: reset state with clipped readback
        check(win_strobe == 3'b000, "R1 strobes", int'(win_strobe), 0);
        check(data_rdy == 1'b0, "R1 data_rdy", int'(data_rdy), 0);
        check(act(0) == 63, "R3 clip high", act(0), 63);
        check(act(1) == -64, "R3 clip low", act(1), -64);
        check(act(2) == 5, "R3 in range", act(2), 5);
        rst = 1'b0; mod_tick = 1'b1;
        // R8: nothing during the first period
        cnt = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            cnt += $countones(win_strobe);
        end
        check(cnt == 0, "R8 first period", cnt, 0);
        // R2: one strobe per channel per period
        cnt = 0;
        for (int i = 0; i < 640; i++) begin
            @(negedge clk);
            cnt += int'(win_strobe[2]);
        end
        check(cnt == 5, "R2 strobes per 5 periods", cnt, 5);
        // R9: no tick, no strobe
        mod_tick = 1'b0;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            cnt += $countones(win_strobe);
        end
        check(cnt == 0, "R9 idle", cnt, 0);
        // R6: mid-period change has no immediate effect (all ties -> ch0)
        set_ph(0, 0, 0);
        repeat (3) @(negedge clk);
        check(act(0) == 63, "R6 hold until wrap", act(0), 63);
        run(700, 1);
        check(act(0) == 0, "R6 applied after wrap", act(0), 0);
        // OSR 64
        osr_code = 4'd0; set_ph(-32, 31, -40);
        run(400, 1);
        check(act(2) == -32, "R3 clip osr64", act(2), -32);
        // OSR 1024 full range
        osr_code = 4'd4; set_ph(-512, 511, 200);
        run(3000, 0);
        check(act(1) == 511, "R3 osr1024 edge", act(1), 511);
        // unused code -> 16384, no clipping
        osr_code = 4'd12; set_ph(-512, 511, -3);
        run(36000, 0);
        check(act(0) == -512 && act(1) == 511, "R4 no clip large osr", act(0), -512);
        // back to OSR 256 with gaps
        osr_code = 4'd2; set_ph(300, -7, 127);
        run(20000, 0);
        check(act(0) == 127, "R3 clip osr256", act(0), 127);
        run(1500, 1);
        finish_up();
    end
endmodule